// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

This block is a synchronous true dual-port memory of 36-bit words. A left port and a right port each have a chip enable, a write select, an address, write data, read data and an active-low interrupt output. Both ports reach the whole array in the same cycle and do not depend on each other.

The two highest addresses also act as mailboxes. The top address belongs to the right port, and the address one below it belongs to the left port. When one port writes the other port's mailbox, the interrupt of that other port goes low. It stays low until the interrupted port reads its own mailbox. The mailbox words keep ordinary data that either port can read and write. So a sender places a message in the word and raises the flag in one access, and the receiver clears the flag when it picks up the message.

When the parameter `MBOX_EN` is 0, the two mailbox words are plain storage and neither interrupt is ever asserted.

Top module: `dpram_mailbox`

## Requirements
- R1: While reset is high, and on the first clock after it, both `l_int_n` and `r_int_n` are 1 and both read-data outputs are 0.
- R2: A read (`ce`=1, `we`=0) shows the addressed word on that port's read data on the next clock. If the other port writes the same address in the same cycle, the read returns the word as it was before that write.
- R3: A port's read data keeps its value in every cycle in which that port does not perform a read.
- R4: If both ports write the same address in the same cycle, the left port's data is stored.
- R5: A left-port write to address 2^ADDR_W-1 drives `r_int_n` to 0 from the next clock.
- R6: A right-port read of address 2^ADDR_W-1 returns `r_int_n` to 1 from the next clock. No other access clears it.
- R7: A right-port write to address 2^ADDR_W-2 drives `l_int_n` to 0 from the next clock. A left-port read of that address returns `l_int_n` to 1.
- R8: A port that writes its own mailbox (left at 2^ADDR_W-2, right at 2^ADDR_W-1) does not change its own interrupt.
- R9: If a set and a clear of the same interrupt happen in the same cycle, the interrupt is asserted after that clock.
- R10: The mailbox words hold 36-bit data that both ports can write and read back like any other location.
- R11: With `MBOX_EN`=0, both interrupts stay 1 at all times, and the mailbox addresses behave as ordinary storage.
- R12: An access with `ce`=0 writes nothing, does not update read data, and neither sets nor clears an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| l_ce | input | 1 | Left port chip enable |
| l_we | input | 1 | Left port write select (1 = write, 0 = read) |
| l_addr | input | ADDR_W | Left port address |
| l_wdata | input | 36 | Left port write data |
| l_rdata | output | 36 | Left port registered read data |
| l_int_n | output | 1 | Left port interrupt, active low |
| r_ce | input | 1 | Right port chip enable |
| r_we | input | 1 | Right port write select (1 = write, 0 = read) |
| r_addr | input | ADDR_W | Right port address |
| r_wdata | input | 36 | Right port write data |
| r_rdata | output | 36 | Right port registered read data |
| r_int_n | output | 1 | Right port interrupt, active low |

## Verification
The hardest cases to reach are the ones where both ports hit a mailbox address in the same cycle. The sender writes the mailbox while the receiver reads it, so a set and a clear of the same flag arrive on one edge, and the receiver's read must also return the word from before the write. Random traffic alone rarely produces this. The stimulus therefore sends about a quarter of all random accesses to the two top addresses, and it also includes directed cycles that pair a write and a read of one mailbox on the same edge. A copy of the block with the feature disabled receives the same inputs and is checked against the same data model, with its interrupts expected to stay inactive.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int WORD_W = 36;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } port_op_e;

    typedef struct packed {
        logic set;
        logic clr;
    } flag_evt_t;

    function automatic port_op_e decode_op(input logic ce, input logic we);
        if (!ce)
            return OP_IDLE;
        return we ? OP_WRITE : OP_READ;
    endfunction

endpackage

// File: rtl/dp_store.sv
module dp_store
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  port_op_e          l_op,
    input  logic [ADDR_W-1:0] l_addr,
    input  word_t             l_wdata,
    output word_t             l_rdata,
    input  port_op_e          r_op,
    input  logic [ADDR_W-1:0] r_addr,
    input  word_t             r_wdata,
    output word_t             r_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    word_t mem [DEPTH];

    // Right write is applied first so that the left write takes priority on a collision.
    always_ff @(posedge clk) begin
        if (r_op == OP_WRITE)
            mem[r_addr] <= r_wdata;
        if (l_op == OP_WRITE)
            mem[l_addr] <= l_wdata;
    end

    // Reads see the array contents from before this edge's writes.
    always_ff @(posedge clk) begin
        if (rst) begin
            l_rdata <= '0;
            r_rdata <= '0;
        end else begin
            if (l_op == OP_READ)
                l_rdata <= mem[l_addr];
            if (r_op == OP_READ)
                r_rdata <= mem[r_addr];
        end
    end
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag
    import mbx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_evt_t evt,
    output logic      int_n
);
    logic pending;

    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else if (evt.set)
            pending <= 1'b1;
        else if (evt.clr)
            pending <= 1'b0;
    end

    assign int_n = ~pending;
endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox
    import mbx_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter bit MBOX_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_ce,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [35:0]       l_wdata,
    output logic [35:0]       l_rdata,
    output logic              l_int_n,
    input  logic              r_ce,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [35:0]       r_wdata,
    output logic [35:0]       r_rdata,
    output logic              r_int_n
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
    localparam int NUM_SIDES = 2;

    port_op_e          op   [NUM_SIDES];
    logic [ADDR_W-1:0] addr [NUM_SIDES];
    logic              irq_n[NUM_SIDES];

    assign op[0]   = decode_op(l_ce, l_we);
    assign op[1]   = decode_op(r_ce, r_we);
    assign addr[0] = l_addr;
    assign addr[1] = r_addr;

    dp_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .l_op    (op[0]),
        .l_addr  (l_addr),
        .l_wdata (l_wdata),
        .l_rdata (l_rdata),
        .r_op    (op[1]),
        .r_addr  (r_addr),
        .r_wdata (r_wdata),
        .r_rdata (r_rdata)
    );

    generate
        if (MBOX_EN) begin : g_mbox
            for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
                // Side 0 (left) owns the word below the top, side 1 (right) owns the top.
                localparam logic [ADDR_W-1:0] OWN_MB = (s == 0) ? TOP_ADDR - 1'b1 : TOP_ADDR;
                localparam int PEER = NUM_SIDES - 1 - s;
                flag_evt_t evt;
                assign evt.set = (op[PEER] == OP_WRITE) && (addr[PEER] == OWN_MB);
                assign evt.clr = (op[s] == OP_READ) && (addr[s] == OWN_MB);
                mbox_flag u_flag (
                    .clk   (clk),
                    .rst   (rst),
                    .evt   (evt),
                    .int_n (irq_n[s])
                );
            end
        end else begin : g_nombox
            for (genvar s = 0; s < NUM_SIDES; s++) begin : g_tie
                assign irq_n[s] = 1'b1;
            end
        end
    endgenerate

    assign l_int_n = irq_n[0];
    assign r_int_n = irq_n[1];
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
    parameter int ADDR_W  = 8,
    parameter bit MBOX_EN = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              l_ce,
    input logic              l_we,
    input logic [ADDR_W-1:0] l_addr,
    input logic [35:0]       l_rdata,
    input logic              l_int_n,
    input logic              r_ce,
    input logic              r_we,
    input logic [ADDR_W-1:0] r_addr,
    input logic [35:0]       r_rdata,
    input logic              r_int_n
);
    localparam logic [ADDR_W-1:0] TOP = '1;
    localparam logic [ADDR_W-1:0] LMB = TOP - 1'b1;

    logic set_r, clr_r, set_l, clr_l;
    assign set_r = MBOX_EN && l_ce && l_we && (l_addr == TOP);
    assign clr_r = r_ce && !r_we && (r_addr == TOP);
    assign set_l = MBOX_EN && r_ce && r_we && (r_addr == LMB);
    assign clr_l = l_ce && !l_we && (l_addr == LMB);

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (l_int_n && r_int_n && l_rdata == '0 && r_rdata == '0));

    a_r3_hold_l: assert property (@(posedge clk) disable iff (rst)
        !(l_ce && !l_we) |=> $stable(l_rdata));

    a_r3_hold_r: assert property (@(posedge clk) disable iff (rst)
        !(r_ce && !r_we) |=> $stable(r_rdata));

    a_r5_set_right: assert property (@(posedge clk) disable iff (rst)
        set_r |=> !r_int_n);

    a_r6_clear_right: assert property (@(posedge clk) disable iff (rst)
        (clr_r && !set_r) |=> r_int_n);

    a_r7_set_left: assert property (@(posedge clk) disable iff (rst)
        set_l |=> !l_int_n);

    a_r7_clear_left: assert property (@(posedge clk) disable iff (rst)
        (clr_l && !set_l) |=> l_int_n);

    a_r12_right_hold: assert property (@(posedge clk) disable iff (rst)
        (!set_r && !clr_r) |=> $stable(r_int_n));

    a_r12_left_hold: assert property (@(posedge clk) disable iff (rst)
        (!set_l && !clr_l) |=> $stable(l_int_n));

    a_r11_disabled: assert property (@(posedge clk)
        !MBOX_EN |-> (l_int_n && r_int_n));
endmodule

bind dpram_mailbox mbx_checker #(.ADDR_W(ADDR_W), .MBOX_EN(MBOX_EN)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .l_ce    (l_ce),
    .l_we    (l_we),
    .l_addr  (l_addr),
    .l_rdata (l_rdata),
    .l_int_n (l_int_n),
    .r_ce    (r_ce),
    .r_we    (r_we),
    .r_addr  (r_addr),
    .r_rdata (r_rdata),
    .r_int_n (r_int_n)
);

// File: tb/tb_dpram_mailbox.sv
`timescale 1ns/1ps
module tb_dpram_mailbox;
    localparam int AW = 8;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] TOP = '1;
    localparam logic [AW-1:0] LMB = TOP - 1'b1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l_ce = 0, l_we = 0, r_ce = 0, r_we = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [35:0] l_wdata = '0, r_wdata = '0;
    logic [35:0] l_rdata, r_rdata, o_l_rdata, o_r_rdata;
    logic l_int_n, r_int_n, o_l_int_n, o_r_int_n;

    always #10 clk = ~clk;

    dpram_mailbox #(.ADDR_W(AW), .MBOX_EN(1'b1)) dut (
        .clk(clk), .rst(rst),
        .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_int_n(l_int_n),
        .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_int_n(r_int_n));

    dpram_mailbox #(.ADDR_W(AW), .MBOX_EN(1'b0)) dut_off (
        .clk(clk), .rst(rst),
        .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(o_l_rdata), .l_int_n(o_l_int_n),
        .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(o_r_rdata), .r_int_n(o_r_int_n));

    int checks = 0;
    int failures = 0;
    string tag = "R1";

    // Behavioural reference
    logic [35:0] mdl_mem [DEPTH];
    logic [35:0] exp_lrd = '0, exp_rrd = '0;
    bit l_pend = 0, r_pend = 0;

    always @(posedge clk) begin
        if (rst) begin
            exp_lrd <= '0; exp_rrd <= '0; l_pend <= 0; r_pend <= 0;
        end else begin
            bit sr, cr, sl, cl;
            sr = l_ce && l_we && l_addr == TOP;
            cr = r_ce && !r_we && r_addr == TOP;
            sl = r_ce && r_we && r_addr == LMB;
            cl = l_ce && !l_we && l_addr == LMB;
            if (l_ce && !l_we) exp_lrd <= mdl_mem[l_addr];
            if (r_ce && !r_we) exp_rrd <= mdl_mem[r_addr];
            if (sr) r_pend <= 1; else if (cr) r_pend <= 0;
            if (sl) l_pend <= 1; else if (cl) l_pend <= 0;
            if (r_ce && r_we) mdl_mem[r_addr] = r_wdata;
            if (l_ce && l_we) mdl_mem[l_addr] = l_wdata;
        end
    end

    task automatic check(input string t, input string what, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check(tag, "l_rdata", l_rdata, exp_lrd);
            check(tag, "r_rdata", r_rdata, exp_rrd);
            check(tag, "l_int_n", {35'd0, l_int_n}, {35'd0, ~l_pend});
            check(tag, "r_int_n", {35'd0, r_int_n}, {35'd0, ~r_pend});
            check("R11", "off l_rdata", o_l_rdata, exp_lrd);
            check("R11", "off r_rdata", o_r_rdata, exp_rrd);
            check("R11", "off ints", {34'd0, o_l_int_n, o_r_int_n}, 36'd3);
        end
    end

    task automatic cyc(input logic lc, input logic lw, input logic [AW-1:0] la, input logic [35:0] ld,
                       input logic rc, input logic rw, input logic [AW-1:0] ra, input logic [35:0] rd);
        @(negedge clk);
        l_ce = lc; l_we = lw; l_addr = la; l_wdata = ld;
        r_ce = rc; r_we = rw; r_addr = ra; r_wdata = rd;
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, '0, '0, 0, 0, '0, '0);
    endtask

    function automatic logic [35:0] pat(input int a);
        return (36'(a) * 36'h1_0003_0005) ^ 36'h5A5_A5A5_A5;
    endfunction

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reset outputs", {l_rdata[33:0], l_int_n, r_int_n}, {34'd0, 2'b11});
        check("R1", "reset r_rdata", r_rdata, '0);
        rst = 0;
        tag = "R1";
        idle(1);
        // Fill the array; left write to TOP also raises the right flag (R5), own mailbox write is silent (R8)
        tag = "R10";
        for (int a = 0; a < DEPTH - 2; a++) cyc(1, 1, AW'(a), pat(a), 0, 0, '0, '0);
        tag = "R8";
        cyc(1, 1, LMB, pat(DEPTH - 2), 0, 0, '0, '0);
        idle(1);
        tag = "R5";
        cyc(1, 1, TOP, pat(DEPTH - 1), 0, 0, '0, '0);
        idle(1);
        tag = "R12";
        cyc(0, 0, '0, '0, 0, 0, TOP, '0);          // read with ce low: no clear, no data update
        cyc(0, 1, 8'd5, 36'h0, 0, 1, 8'd6, 36'h0);  // writes with ce low: nothing stored
        cyc(1, 0, 8'd5, '0, 1, 0, 8'd6, '0);
        tag = "R6";
        cyc(0, 0, '0, '0, 1, 0, TOP, '0);
        idle(1);
        tag = "R8";
        cyc(0, 0, '0, '0, 1, 1, TOP, 36'h123456789);
        idle(1);
        tag = "R7";
        cyc(0, 0, '0, '0, 1, 1, LMB, 36'hABCDEF012);
        idle(1);
        cyc(1, 0, LMB, '0, 0, 0, '0, '0);
        tag = "R3";
        idle(3);
        tag = "R4";
        cyc(1, 1, 8'd10, 36'h111111111, 1, 1, 8'd10, 36'h222222222);
        cyc(1, 0, 8'd10, '0, 1, 0, 8'd10, '0);
        tag = "R2";
        cyc(1, 1, 8'd20, 36'hFEDCBA987, 1, 0, 8'd20, '0);
        cyc(0, 0, '0, '0, 1, 0, 8'd20, '0);
        tag = "R9";
        cyc(1, 1, TOP, 36'h0F0F0F0F0, 0, 0, '0, '0);
        cyc(1, 1, TOP, 36'h00000ABCD, 1, 0, TOP, '0);   // set and clear together: stays set, read returns old
        idle(1);
        cyc(0, 0, '0, '0, 1, 1, LMB, 36'h333);
        cyc(1, 0, LMB, '0, 1, 1, LMB, 36'h444);          // left clear with right set: stays set
        idle(1);
        tag = "R10";
        cyc(1, 0, TOP, '0, 1, 0, LMB, '0);
        tag = "R2";
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] la, ra;
            la = ($urandom % 4 == 0) ? (LMB + AW'($urandom % 2)) : AW'($urandom);
            ra = ($urandom % 4 == 0) ? (LMB + AW'($urandom % 2)) : AW'($urandom);
            cyc(1'($urandom), 1'($urandom), la, {$urandom, 4'($urandom)},
                1'($urandom), 1'($urandom), ra, {$urandom, 4'($urandom)});
        end
        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule